// File: doc/BRIEF.md
# Output-Disable Request Input Qualifier

This block watches three active-low emergency request pins. For each pin it raises a sticky request flag once that pin's qualification rule is met. Each pin has its own 2-bit mode. One mode reacts to a single falling edge. The other three modes act as a noise filter: the pin must read low on 16 consecutive samples, and the samples are taken on strobes at one of three divided rates of the block clock.

The three flags are ORed into one output-disable request. That request stays high until software has cleared every flag.

Software reaches the block through a small register port with two addresses. The mode register can be written once after each reset. After that it is frozen. A flag clears only when software writes 0 to it after a read that returned it as 1. If a new qualifying event arrives in the same cycle as a valid clear, the event wins and the flag stays set.

Top module: `odis_qualifier`

## Requirements
- R1: After reset all flags are 0, the mode register reads 0 (every channel in edge mode) and `odis_req` is 0.
- R2: The mode register is at address 0. Channel 0's mode is in bits 1:0, channel 1's in bits 3:2 and channel 2's in bits 5:4. A read returns the value written.
- R3: Only the first write to the mode register after reset takes effect. Later writes leave the read value and the qualification behaviour unchanged until the next reset.
- R4: In mode 00, a high-to-low transition on the synchronized pin sets that channel's flag on the third rising clock edge after the pin changes. A pin that stays low does not set the flag again, and a low-to-high transition sets nothing.
- R5: In mode 01, the flag is set when 16 consecutive samples taken every 8 clocks all read low. A sample that reads high restarts the count, so a low stretch shorter than 16 samples sets nothing.
- R6: In mode 10, the same 16-sample rule applies with a sample every 16 clocks.
- R7: In mode 11, the same 16-sample rule applies with a sample every 128 clocks.
- R8: The flag register is at address 1, with bit i holding channel i's flag. Writing 0 to bit i clears that flag only if bit i read as 1 in a flag-register read made after the last flag-register write. Writing 1, or writing 0 without such a read, has no effect.
- R9: When a qualifying event and a valid clear reach the same flag in the same cycle, the flag stays 1.
- R10: `odis_req` is high whenever any flag is set, and it stays high until all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the sample rates are derived from it |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| req_n | input | 3 | Active-low request pins, one per channel, asynchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks flags as read) |
| reg_addr | input | 1 | 0 selects the mode register, 1 the flag register |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data for the selected register, combinational |
| odis_req | output | 1 | Combined output-disable request |

## Verification
A pin change driven between clock edges is registered twice by the synchronizer and then sets the flag, so an edge-mode flag is due on the third rising edge. The bench reads `odis_req` after two edges, expecting 0, and after three, expecting 1. A filter-mode flag is due only after 16 strobes, and strobes are not aligned to the stimulus. The bench therefore uses low windows whose length bounds the number of strobes they can contain. A window of 14 sample periods must leave the flag clear, and one of 17 sample periods plus a margin must set it. Register reads are combinational and are sampled in the cycle the strobe is driven. A write takes effect at the next edge, so each write is checked with a later read. For the clear-versus-event collision, the write is placed at exactly the edge where the edge event registers.

// File: rtl/odq_pkg.sv
// Package: shared encodings for the output-disable request qualifier.
// Assumes: one 2-bit mode per channel and a 1-bit register address.
package odq_pkg;

    typedef enum logic [1:0] {
        QM_EDGE  = 2'b00,
        QM_SLOW1 = 2'b01,
        QM_SLOW2 = 2'b10,
        QM_SLOW3 = 2'b11
    } qual_mode_e;

    localparam int unsigned MODE_W    = 2;
    localparam logic        ADDR_MODE = 1'b0;
    localparam logic        ADDR_FLAG = 1'b1;

endpackage

// File: rtl/odq_prescaler.sv
// Module: odq_prescaler
// A free-running counter that gives one single-cycle strobe per divider.
// Assumes: every divider is a power of two greater than 1, and DIV_C is the largest.
module odq_prescaler #(
    parameter int unsigned DIV_A = 8,
    parameter int unsigned DIV_B = 16,
    parameter int unsigned DIV_C = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] strobe
);
    localparam int unsigned PW = $clog2(DIV_C);
    localparam int unsigned DIV_TAB [3] = '{DIV_A, DIV_B, DIV_C};

    logic [PW-1:0] cnt;

    // Purpose: advance the shared divide counter on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < 3; g++) begin : g_strobe
        localparam logic [PW-1:0] MASK = PW'(DIV_TAB[g] - 1);
        // Purpose: pulse when the low bits of the counter wrap to all ones.
        always_comb strobe[g] = ((cnt & MASK) == MASK);

        AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            strobe[g] |=> !strobe[g]);  // R5
    end

endmodule

// File: rtl/odq_channel.sv
// Module: odq_channel
// Qualifies one active-low request pin: two-flop synchronizer, falling-edge
// detect, and a saturating run-of-lows counter that advances on the
// selected strobe. Drives a one-cycle qualifying event.
// Assumes: mode stays stable once written; strobes are single-cycle pulses.
module odq_channel
    import odq_pkg::*;
#(
    parameter int unsigned SAMPLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [2:0]        strobe,
    output logic              evt
);
    localparam int unsigned CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] FULL = CW'(SAMPLES);
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    qual_mode_e  qm;
    logic        s1, s2, prev;
    logic        tick;
    logic [CW-1:0] run;

    // Purpose: decode the mode field into the enum.
    always_comb qm = qual_mode_e'(mode);

    // Purpose: synchronize the pin and keep its previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= req_n;
            s2   <= s1;
            prev <= s2;
        end
    end

    // Purpose: pick the sample strobe that belongs to this channel's mode.
    always_comb begin
        unique case (qm)
            QM_SLOW1: tick = strobe[0];
            QM_SLOW2: tick = strobe[1];
            QM_SLOW3: tick = strobe[2];
            default:  tick = 1'b0;
        endcase
    end

    // Purpose: count consecutive low samples, clear on a high sample, saturate at full.
    always_ff @(posedge clk) begin
        if (!rst_n || qm == QM_EDGE) begin
            run <= '0;
        end else if (tick) begin
            if (s2)               run <= '0;
            else if (run != FULL) run <= run + 1'b1;
        end
    end

    // Purpose: produce the qualifying event for the current mode.
    always_comb begin
        if (qm == QM_EDGE) evt = prev && !s2;
        else               evt = tick && !s2 && (run == LAST);
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run <= FULL);  // R5
    AST_FILTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (qm != QM_EDGE && evt) |=> (run == FULL));  // R5
    AST_EDGE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (qm == QM_EDGE) |=> (run == '0));  // R4

endmodule

// File: rtl/odq_regs.sv
// Module: odq_regs
// Holds the write-once mode register, the sticky request flags and the
// per-flag "read as one" marks that enable clearing.
// Assumes: reg_rdata is sampled combinationally in the cycle of the read strobe.
module odq_regs
    import odq_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic                   addr,
    input  logic [MODE_W*NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0]      evt,
    output logic [MODE_W*NUM_CH-1:0] mode_bits,
    output logic [NUM_CH-1:0]      flags,
    output logic [MODE_W*NUM_CH-1:0] rdata
);
    logic              locked;
    logic [NUM_CH-1:0] armed;
    logic              wr_mode, wr_flag, rd_flag;

    // Purpose: decode register strobes.
    always_comb begin
        wr_mode = wr_en && (addr == ADDR_MODE);
        wr_flag = wr_en && (addr == ADDR_FLAG);
        rd_flag = rd_en && (addr == ADDR_FLAG);
    end

    // Purpose: accept the first mode write after reset and freeze afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_bits <= '0;
            locked    <= 1'b0;
        end else if (wr_mode && !locked) begin
            mode_bits <= wdata;
            locked    <= 1'b1;
        end
    end

    // Purpose: remember which flags a read returned as one; any flag write consumes the marks.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= '0;
        else if (wr_flag) armed <= '0;
        else if (rd_flag) armed <= flags;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
        logic clr_ok;
        // Purpose: a clear needs a zero written to a bit that was read as one.
        always_comb clr_ok = wr_flag && !wdata[i] && armed[i];

        // Purpose: sticky flag, with set taking priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (evt[i]) flags[i] <= 1'b1;
            else if (clr_ok) flags[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flags[i]);  // R9
        AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(evt[i]));  // R4
        AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(wr_flag && !wdata[i] && armed[i]));  // R8
    end

    // Purpose: return the addressed register.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_FLAG) rdata[NUM_CH-1:0] = flags;
        else                   rdata = mode_bits;
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(mode_bits));  // R3

endmodule

// File: rtl/odis_qualifier.sv
// Module: odis_qualifier (top)
// Three request channels sharing one prescaler and one register block. The
// combined output-disable request is the OR of the sticky flags.
// Assumes: the request pins are asynchronous; reset is synchronous and active low.
module odis_qualifier
    import odq_pkg::*;
#(
    parameter int unsigned NUM_CH  = 3,
    parameter int unsigned SAMPLES = 16,
    parameter int unsigned DIV_A   = 8,
    parameter int unsigned DIV_B   = 16,
    parameter int unsigned DIV_C   = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic                     reg_addr,
    input  logic [MODE_W*NUM_CH-1:0] reg_wdata,
    output logic [MODE_W*NUM_CH-1:0] reg_rdata,
    output logic                     odis_req
);
    localparam int unsigned MW = MODE_W * NUM_CH;

    logic [2:0]        strobe;
    logic [MW-1:0]     mode_bits;
    logic [NUM_CH-1:0] evt;
    logic [NUM_CH-1:0] flags;

    odq_prescaler #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B),
        .DIV_C (DIV_C)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        odq_channel #(
            .SAMPLES (SAMPLES)
        ) u_channel (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_n  (req_n[c]),
            .mode   (mode_bits[MODE_W*c +: MODE_W]),
            .strobe (strobe),
            .evt    (evt[c])
        );
    end

    odq_regs #(
        .NUM_CH (NUM_CH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .evt       (evt),
        .mode_bits (mode_bits),
        .flags     (flags),
        .rdata     (reg_rdata)
    );

    // Purpose: combine the sticky flags into one request.
    always_comb odis_req = |flags;

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(odis_req) |-> $past(reg_wr && reg_addr == ADDR_FLAG));  // R10

endmodule

// File: tb/odis_qualifier_bench.sv
module odis_qualifier_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_n = 3'b111;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_addr = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic       odis_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    odis_qualifier u_odis_qualifier (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (req_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .odis_req  (odis_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic write_reg(input logic a, input logic [5:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic a, output logic [5:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_n = 3'b111;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [2:0] after_clear(logic [2:0] f, logic [2:0] armed, logic [2:0] w);
        return f & (w | ~armed);
    endfunction

    // Filter test for one channel with sample period d clocks.
    task automatic filter_run(input int ch, input int d, input string tag);
        logic [5:0] v;
        // low stretches broken by a high stretch long enough to hold two samples
        @(negedge clk); req_n[ch] = 1'b0;
        repeat (10 * d) @(negedge clk);
        req_n[ch] = 1'b1;
        repeat (2 * d) @(negedge clk);
        req_n[ch] = 1'b0;
        repeat (10 * d) @(negedge clk);
        req_n[ch] = 1'b1;
        repeat (3 * d) @(negedge clk);
        read_reg(1'b1, v);
        check({tag, " high sample restarts count"}, v[ch], 1'b0);
        // one stretch holding at most 14 samples
        @(negedge clk); req_n[ch] = 1'b0;
        repeat (14 * d) @(negedge clk);
        req_n[ch] = 1'b1;
        repeat (3 * d) @(negedge clk);
        read_reg(1'b1, v);
        check({tag, " short low ignored"}, v[ch], 1'b0);
        // one stretch holding at least 16 samples
        @(negedge clk); req_n[ch] = 1'b0;
        repeat (17 * d + 6) @(negedge clk);
        read_reg(1'b1, v);
        check({tag, " 16 low samples set flag"}, v[ch], 1'b1);
        req_n[ch] = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [5:0] v;
        logic [2:0] exp_f;
        void'($urandom(32'd20240611));
        do_reset();

        // R1: reset state
        check("R1 odis_req after reset", odis_req, 1'b0);
        read_reg(1'b0, v);
        check("R1 mode after reset", v, 6'h00);
        read_reg(1'b1, v);
        check("R1 flags after reset", v, 6'h00);

        // R4: edge timing on channel 0, due on the third rising edge
        @(negedge clk); req_n[0] = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 not yet after two edges", odis_req, 1'b0);
        @(negedge clk);
        check("R4 set on third edge", odis_req, 1'b1);
        repeat (20) @(negedge clk);
        read_reg(1'b1, v);
        check("R4 flag 0 set", v, 6'h01);
        write_reg(1'b1, 6'h00);
        repeat (20) @(negedge clk);
        read_reg(1'b1, v);
        check("R4 held low does not retrigger", v, 6'h00);
        req_n[0] = 1'b1;
        repeat (10) @(negedge clk);
        read_reg(1'b1, v);
        check("R4 rising edge sets nothing", v, 6'h00);

        // R8: clear rules on channel 1
        @(negedge clk); req_n[1] = 1'b0;
        repeat (3) @(negedge clk); req_n[1] = 1'b1;
        repeat (5) @(negedge clk);
        write_reg(1'b1, 6'h00);
        read_reg(1'b1, v);
        check("R8 zero without read ignored", v, 6'h02);
        write_reg(1'b1, 6'h07);
        read_reg(1'b1, v);
        check("R8 writing one ignored", v, 6'h02);
        write_reg(1'b1, 6'h00);
        read_reg(1'b1, v);
        check("R8 read then zero clears", v, 6'h00);

        // R9: event and valid clear in the same cycle on channel 0
        @(negedge clk); req_n[0] = 1'b0;
        repeat (3) @(negedge clk); req_n[0] = 1'b1;
        repeat (5) @(negedge clk);
        read_reg(1'b1, v);
        @(negedge clk); req_n[0] = 1'b0;
        @(negedge clk);
        write_reg(1'b1, 6'h00);
        read_reg(1'b1, v);
        check("R9 set wins over clear", v, 6'h01);
        req_n[0] = 1'b1;
        repeat (4) @(negedge clk);
        read_reg(1'b1, v);
        write_reg(1'b1, 6'h00);

        // R4/R8/R10: random pulses and random clears in edge mode
        exp_f = 3'b000;
        for (int it = 0; it < 24; it++) begin
            logic [2:0] mask;
            logic [2:0] w;
            mask = 3'($urandom % 8);
            w    = 3'($urandom % 8);
            @(negedge clk); req_n = ~mask;
            repeat (3) @(negedge clk);
            req_n = 3'b111;
            repeat (5) @(negedge clk);
            exp_f = exp_f | mask;
            read_reg(1'b1, v);
            check("R4 random pulse flags", v, {3'b000, exp_f});
            check("R10 random odis_req", odis_req, |exp_f);
            if ($urandom % 2 == 0) begin
                write_reg(1'b1, {3'b000, w});
                exp_f = after_clear(exp_f, exp_f, w);
            end else begin
                write_reg(1'b1, 6'h07);
                write_reg(1'b1, {3'b000, w});
            end
        end

        // R2/R3: write-once mode register
        do_reset();
        write_reg(1'b0, 6'h39);
        read_reg(1'b0, v);
        check("R2 mode readback", v, 6'h39);
        write_reg(1'b0, 6'h00);
        read_reg(1'b0, v);
        check("R3 second mode write ignored", v, 6'h39);

        // R3: channel 0 is still filtered, so a short low pulse sets nothing
        @(negedge clk); req_n[0] = 1'b0;
        repeat (3) @(negedge clk); req_n[0] = 1'b1;
        repeat (6) @(negedge clk);
        read_reg(1'b1, v);
        check("R3 edge mode not restored", v, 6'h00);

        filter_run(0, 8,   "R5");
        filter_run(1, 16,  "R6");
        filter_run(2, 128, "R7");

        // R10: request follows the flags until all are cleared
        read_reg(1'b1, v);
        check("R10 all flags set", v, 6'h07);
        write_reg(1'b1, 6'h06);
        @(negedge clk);
        check("R10 request held with flags left", odis_req, 1'b1);
        read_reg(1'b1, v);
        write_reg(1'b1, 6'h00);
        @(negedge clk);
        check("R10 request drops when all clear", odis_req, 1'b0);

        summary();
    end
endmodule